// File: doc/BRIEF.md
# Timer Interrupt Controller with Saved-State Stack

This block gives a processor a software-programmed countdown timer as its interrupt source and a small hardware stack that keeps the state of interrupted code. Software writes a start value, and the timer counts down one step per clock. When the count reaches zero through counting, an interrupt becomes pending. The fetch stage asks whether it may take that interrupt. The block grants it only while the processor runs on its committed path, and never while speculative execution is in progress. On a grant, the current fetch PC and a state word are pushed. Fetch is then sent to a fixed handler address without first emptying the reorder structures.

When the handler finishes, a return request pops the newest saved entry and hands the saved PC and state back to fetch. Entries nest in last-in, first-out order, so interrupts may be taken again inside a handler up to the stack depth. A sticky error flag records two faults: an attempt to save when the stack is full, and an attempt to return when it is empty. Each redirect to fetch is a registered one-cycle pulse that follows the accepting clock edge.

Top module: `irq_timer_stack`

## Requirements
- R1: A cycle with `tmr_wr` high loads `tmr_val` into the counter (`tmr_count`), visible after that edge. On every other cycle a nonzero count drops by one, and a count of zero stays at zero.
- R2: After a load of a nonzero value N, `irq_pend` rises exactly N cycles later, at the same edge where the count reaches zero. It rises once per load. A load of zero arms nothing. Any load clears a pending interrupt.
- R3: While `spec_mode` is high, no interrupt is taken. `irq_pend` stays high and nothing is pushed.
- R4: An interrupt is taken when `fetch_chk` and `irq_pend` are high, `spec_mode` is low, `rti_req` is low and the stack is not full. In the next cycle `redir_vld`=1, `redir_ret`=0, `redir_pc`=`VEC_PC` and `irq_pend`=0.
- R5: Taking an interrupt stores `cur_pc` and `cur_state` at the current stack level and raises `stk_level` by one.
- R6: With `rti_req` high and `stk_level` nonzero, in the next cycle `stk_level` drops by one and `redir_vld`=1, `redir_ret`=1. At the same time `redir_pc` and `rest_state` give the most recently saved entry (last-in, first-out).
- R7: When `rti_req` and a grantable interrupt fall in the same cycle, only the return is performed. `irq_pend` stays high and the interrupt can be taken on a later check.
- R8: An entry attempt while `stk_level` equals `DEPTH`, or a return while `stk_level` is 0, sets `stk_err`. It leaves `stk_level` unchanged and produces no redirect. A refused entry leaves `irq_pend` high.
- R9: Once set, `stk_err` stays high until reset.
- R10: After reset, `tmr_count`=0, `irq_pend`=0, `stk_level`=0, `stk_err`=0 and `redir_vld`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr_wr | input | 1 | Software write strobe for the timer |
| tmr_val | input | TW | Timer start value |
| fetch_chk | input | 1 | Fetch stage asks whether an interrupt may be taken |
| spec_mode | input | 1 | Processor is executing speculatively |
| cur_pc | input | PW | Fetch PC to save on entry |
| cur_state | input | SW | Processor state word to save on entry |
| rti_req | input | 1 | Return-from-interrupt request |
| redir_vld | output | 1 | One-cycle redirect pulse to fetch |
| redir_pc | output | PW | Redirect target |
| redir_ret | output | 1 | 1 when the redirect is a return, 0 for handler entry |
| rest_state | output | SW | State word restored by the last return |
| tmr_count | output | TW | Current timer count |
| irq_pend | output | 1 | Timer interrupt pending |
| stk_level | output | LW | Number of saved entries |
| stk_err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The two functions that can coincide are interrupt entry and return. A fetch check that finds a pending interrupt outside speculative mode can arrive in the same cycle as a return request. The bench forces this collision directly by arming the timer and then raising `fetch_chk` and `rti_req` together. It also lets the random phase raise both at will. The collision is judged by the redirect, which must be a return carrying the newest saved PC. The level must fall by one, and the interrupt must still be pending for the next check.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic {
        REDIR_VEC = 1'b0,
        REDIR_RET = 1'b1
    } redir_kind_e;

endpackage

// File: rtl/irq_countdown.sv
module irq_countdown #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [TW-1:0] ld_val,
    input  logic          ack,
    output logic [TW-1:0] count,
    output logic          pend
);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          armed;
        logic          pend;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (ack) begin
            t_d.pend = 1'b0;
        end
        if (ld) begin
            t_d.cnt   = ld_val;
            t_d.armed = (ld_val != '0);
            t_d.pend  = 1'b0;
        end else if (t_q.cnt != '0) begin
            t_d.cnt = t_q.cnt - TW'(1);
            if (t_q.cnt == TW'(1) && t_q.armed) begin
                t_d.pend  = 1'b1;
                t_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign count = t_q.cnt;
    assign pend  = t_q.pend;

endmodule

// File: rtl/irq_state_stack.sv
module irq_state_stack #(
    parameter int PW    = 32,
    parameter int SW    = 16,
    parameter int DEPTH = 8,
    parameter int LW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [PW-1:0] push_pc,
    input  logic [SW-1:0] push_st,
    output logic [PW-1:0] top_pc,
    output logic [SW-1:0] top_st,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          err
);

    typedef struct packed {
        logic [PW-1:0] pc;
        logic [SW-1:0] st;
    } frame_t;

    frame_t          mem_d [DEPTH];
    frame_t          mem_q [DEPTH];
    logic [LW-1:0]   ptr_d, ptr_q;
    logic            err_d, err_q;
    logic [LW-1:0]   top_idx;
    frame_t          top_f;

    assign full    = (ptr_q == LW'(DEPTH));
    assign empty   = (ptr_q == '0);
    assign top_idx = ptr_q - LW'(1);

    always_comb begin
        top_f = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (LW'(i) == top_idx) begin
                top_f = mem_q[i];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        ptr_d = ptr_q;
        err_d = err_q;
        if (pop) begin
            if (empty) begin
                err_d = 1'b1;
            end else begin
                ptr_d = ptr_q - LW'(1);
            end
        end else if (push) begin
            if (full) begin
                err_d = 1'b1;
            end else begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (LW'(i) == ptr_q) begin
                        mem_d[i].pc = push_pc;
                        mem_d[i].st = push_st;
                    end
                end
                ptr_d = ptr_q + LW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
            ptr_q <= '0;
            err_q <= 1'b0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
            ptr_q <= ptr_d;
            err_q <= err_d;
        end
    end

    assign top_pc = top_f.pc;
    assign top_st = top_f.st;
    assign level  = ptr_q;
    assign err    = err_q;

endmodule

// File: rtl/irq_timer_stack.sv
module irq_timer_stack
    import irq_pkg::*;
#(
    parameter int          TW     = 16,
    parameter int          PW     = 32,
    parameter int          SW     = 16,
    parameter int          DEPTH  = 8,
    parameter logic [31:0] VEC_PC = 32'h0000_0180,
    localparam int         LW     = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tmr_wr,
    input  logic [TW-1:0] tmr_val,
    input  logic          fetch_chk,
    input  logic          spec_mode,
    input  logic [PW-1:0] cur_pc,
    input  logic [SW-1:0] cur_state,
    input  logic          rti_req,
    output logic          redir_vld,
    output logic [PW-1:0] redir_pc,
    output logic          redir_ret,
    output logic [SW-1:0] rest_state,
    output logic [TW-1:0] tmr_count,
    output logic          irq_pend,
    output logic [LW-1:0] stk_level,
    output logic          stk_err
);

    typedef struct packed {
        logic          vld;
        redir_kind_e   kind;
        logic [PW-1:0] pc;
        logic [SW-1:0] st;
    } redir_t;

    redir_t        out_d, out_q;
    logic          ent_try, ent_ok, ret_ok;
    logic          stk_full, stk_empty;
    logic [PW-1:0] top_pc;
    logic [SW-1:0] top_st;

    // return wins over entry when both fall in one cycle
    assign ent_try = fetch_chk && irq_pend && !spec_mode && !rti_req;
    assign ent_ok  = ent_try && !stk_full;
    assign ret_ok  = rti_req && !stk_empty;

    irq_countdown #(.TW(TW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (tmr_wr),
        .ld_val (tmr_val),
        .ack    (ent_ok),
        .count  (tmr_count),
        .pend   (irq_pend)
    );

    irq_state_stack #(.PW(PW), .SW(SW), .DEPTH(DEPTH), .LW(LW)) u_stk (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (ent_try),
        .pop     (rti_req),
        .push_pc (cur_pc),
        .push_st (cur_state),
        .top_pc  (top_pc),
        .top_st  (top_st),
        .level   (stk_level),
        .full    (stk_full),
        .empty   (stk_empty),
        .err     (stk_err)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = 1'b0;
        if (ret_ok) begin
            out_d.vld  = 1'b1;
            out_d.kind = REDIR_RET;
            out_d.pc   = top_pc;
            out_d.st   = top_st;
        end else if (ent_ok) begin
            out_d.vld  = 1'b1;
            out_d.kind = REDIR_VEC;
            out_d.pc   = PW'(VEC_PC);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign redir_vld  = out_q.vld;
    assign redir_pc   = out_q.pc;
    assign redir_ret  = (out_q.kind == REDIR_RET);
    assign rest_state = out_q.st;

endmodule

// File: rtl/irq_timer_stack_chk.sv
module irq_timer_stack_chk #(
    parameter int TW    = 16,
    parameter int DEPTH = 8,
    parameter int LW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tmr_wr,
    input logic          fetch_chk,
    input logic          spec_mode,
    input logic          rti_req,
    input logic          redir_vld,
    input logic          redir_ret,
    input logic [TW-1:0] tmr_count,
    input logic          irq_pend,
    input logic [LW-1:0] stk_level,
    input logic          stk_err
);

    a_r1_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_wr && tmr_count != '0) |=> (tmr_count == $past(tmr_count) - TW'(1)));

    a_r3_no_entry_in_spec: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_mode && !rti_req) |=> !redir_vld);

    a_r4_entry_clears_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_chk && irq_pend && !spec_mode && !rti_req && !tmr_wr
         && stk_level != LW'(DEPTH)) |=> (!irq_pend && redir_vld && !redir_ret));

    a_r5_push_level: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_chk && irq_pend && !spec_mode && !rti_req && stk_level != LW'(DEPTH))
        |=> (stk_level == $past(stk_level) + LW'(1)));

    a_r6_pop_level: assert property (@(posedge clk) disable iff (!rst_n)
        (rti_req && stk_level != '0)
        |=> (stk_level == $past(stk_level) - LW'(1) && redir_vld && redir_ret));

    a_r7_return_keeps_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (rti_req && fetch_chk && irq_pend && !tmr_wr) |=> irq_pend);

    a_r8_full_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_chk && irq_pend && !spec_mode && !rti_req && stk_level == LW'(DEPTH))
        |=> (stk_err && stk_level == LW'(DEPTH) && !redir_vld));

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stk_err |=> stk_err);

    a_r9_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        stk_level <= LW'(DEPTH));

endmodule

bind irq_timer_stack irq_timer_stack_chk #(.TW(TW), .DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tmr_wr    (tmr_wr),
    .fetch_chk (fetch_chk),
    .spec_mode (spec_mode),
    .rti_req   (rti_req),
    .redir_vld (redir_vld),
    .redir_ret (redir_ret),
    .tmr_count (tmr_count),
    .irq_pend  (irq_pend),
    .stk_level (stk_level),
    .stk_err   (stk_err)
);

// File: tb/irq_timer_stack_test.sv
module irq_timer_stack_test;

    localparam int          CLK_PERIOD = 10;
    localparam int          TW    = 16;
    localparam int          PW    = 32;
    localparam int          SW    = 16;
    localparam int          DEPTH = 8;
    localparam int          LW    = $clog2(DEPTH + 1);
    localparam logic [31:0] VEC   = 32'h0000_0180;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tmr_wr = 1'b0;
    logic [TW-1:0] tmr_val = '0;
    logic          fetch_chk = 1'b0;
    logic          spec_mode = 1'b0;
    logic [PW-1:0] cur_pc = '0;
    logic [SW-1:0] cur_state = '0;
    logic          rti_req = 1'b0;
    logic          redir_vld, redir_ret, irq_pend, stk_err;
    logic [PW-1:0] redir_pc;
    logic [SW-1:0] rest_state;
    logic [TW-1:0] tmr_count;
    logic [LW-1:0] stk_level;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // bench model state
    logic [TW-1:0] m_cnt;
    bit            m_armed, m_pend, m_err, m_vld, m_ret;
    int            m_lvl;
    logic [PW-1:0] m_rpc;
    logic [SW-1:0] m_rst;
    logic [PW-1:0] m_spc [DEPTH];
    logic [SW-1:0] m_sst [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_timer_stack #(.TW(TW), .PW(PW), .SW(SW), .DEPTH(DEPTH), .VEC_PC(VEC)) uut (
        .clk(clk), .rst_n(rst_n), .tmr_wr(tmr_wr), .tmr_val(tmr_val),
        .fetch_chk(fetch_chk), .spec_mode(spec_mode), .cur_pc(cur_pc),
        .cur_state(cur_state), .rti_req(rti_req), .redir_vld(redir_vld),
        .redir_pc(redir_pc), .redir_ret(redir_ret), .rest_state(rest_state),
        .tmr_count(tmr_count), .irq_pend(irq_pend), .stk_level(stk_level),
        .stk_err(stk_err)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [TW-1:0] next_count(input logic [TW-1:0] c, input bit wr,
                                                 input logic [TW-1:0] v);
        if (wr) return v;
        if (c != '0) return c - TW'(1);
        return c;
    endfunction

    task automatic model_reset();
        m_cnt = '0; m_armed = 0; m_pend = 0; m_err = 0;
        m_vld = 0; m_ret = 0; m_lvl = 0; m_rpc = '0; m_rst = '0;
    endtask

    task automatic model_step(input bit wr, input logic [TW-1:0] v, input bit fc,
                              input bit sp, input logic [PW-1:0] pc,
                              input logic [SW-1:0] st, input bit rti);
        bit try_ent, took;
        bit n_pend;
        try_ent = fc && m_pend && !sp && !rti;
        took = 0;
        m_vld = 0;
        if (rti) begin
            if (m_lvl == 0) m_err = 1;
            else begin
                m_lvl--;
                m_vld = 1; m_ret = 1;
                m_rpc = m_spc[m_lvl]; m_rst = m_sst[m_lvl];
            end
        end else if (try_ent) begin
            if (m_lvl == DEPTH) m_err = 1;
            else begin
                m_spc[m_lvl] = pc; m_sst[m_lvl] = st; m_lvl++;
                m_vld = 1; m_ret = 0; m_rpc = VEC;
                took = 1;
            end
        end
        n_pend = took ? 1'b0 : m_pend;
        if (wr) begin
            m_armed = (v != '0);
            n_pend  = 0;
        end else if (m_cnt == TW'(1) && m_armed) begin
            n_pend  = 1;
            m_armed = 0;
        end
        m_pend = n_pend;
        m_cnt  = next_count(m_cnt, wr, v);
    endtask

    task automatic compare();
        check(tmr_count == m_cnt, "R1 timer count", 64'(tmr_count), 64'(m_cnt));
        check(irq_pend == m_pend, "R2 pending", 64'(irq_pend), 64'(m_pend));
        check(stk_level == LW'(m_lvl), "R5 level", 64'(stk_level), 64'(m_lvl));
        check(stk_err == m_err, "R9 error flag", 64'(stk_err), 64'(m_err));
        check(redir_vld == m_vld, "R4 redirect valid", 64'(redir_vld), 64'(m_vld));
        if (m_vld) begin
            check(redir_ret == m_ret, "R6 redirect kind", 64'(redir_ret), 64'(m_ret));
            check(redir_pc == m_rpc, "R6 redirect pc", 64'(redir_pc), 64'(m_rpc));
            if (m_ret)
                check(rest_state == m_rst, "R6 restored state", 64'(rest_state), 64'(m_rst));
        end
    endtask

    // called at a negedge; returns at the next negedge after comparing
    task automatic step(input bit wr, input logic [TW-1:0] v, input bit fc, input bit sp,
                        input logic [PW-1:0] pc, input logic [SW-1:0] st, input bit rti);
        tmr_wr = wr; tmr_val = v; fetch_chk = fc; spec_mode = sp;
        cur_pc = pc; cur_state = st; rti_req = rti;
        model_step(wr, v, fc, sp, pc, st, rti);
        @(posedge clk);
        @(negedge clk);
        tmr_wr = 0; fetch_chk = 0; rti_req = 0; spec_mode = 0;
        compare();
    endtask

    task automatic idle();
        step(0, '0, 0, 0, '0, '0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        tmr_wr = 0; fetch_chk = 0; rti_req = 0; spec_mode = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        model_reset();
        // R10: reset state
        check(tmr_count == '0, "R10 count", 64'(tmr_count), 0);
        check(irq_pend == 0, "R10 pending", 64'(irq_pend), 0);
        check(stk_level == '0, "R10 level", 64'(stk_level), 0);
        check(stk_err == 0, "R10 error", 64'(stk_err), 0);
        check(redir_vld == 0, "R10 redirect", 64'(redir_vld), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();

        // R1/R2: load 3, pending on third cycle exactly
        step(1, 16'd3, 0, 0, '0, '0, 0);
        check(tmr_count == 16'd3, "R1 load value", 64'(tmr_count), 3);
        idle(); idle();
        check(irq_pend == 0, "R2 not early", 64'(irq_pend), 0);
        idle();
        check(irq_pend == 1, "R2 on zero", 64'(irq_pend), 1);
        idle();
        check(tmr_count == '0, "R1 saturate", 64'(tmr_count), 0);

        // R3: speculative mode holds interrupt off
        step(0, '0, 1, 1, 32'h1000, 16'h00A1, 0);
        check(redir_vld == 0 && irq_pend == 1, "R3 held in spec",
              64'({redir_vld, irq_pend}), 64'(2'b01));

        // R4/R5: accept
        step(0, '0, 1, 0, 32'h1004, 16'h00A2, 0);
        check(redir_pc == VEC && redir_ret == 0, "R4 vector", 64'(redir_pc), 64'(VEC));
        check(stk_level == LW'(1), "R5 level one", 64'(stk_level), 1);

        // R7: return and entry together
        step(1, 16'd1, 0, 0, '0, '0, 0);
        idle();
        step(0, '0, 1, 0, 32'h2000, 16'h00B0, 1);
        check(redir_ret == 1 && redir_pc == 32'h1004, "R7 return wins",
              64'(redir_pc), 64'h1004);
        check(irq_pend == 1, "R7 pend kept", 64'(irq_pend), 1);

        // fill stack
        for (int i = 0; i < DEPTH; i++) begin
            step(0, '0, 1, 0, 32'h3000 + 32'(i * 4), 16'(16'hC0 + i), 0);
            step(1, 16'd1, 0, 0, '0, '0, 0);
            idle();
        end
        check(stk_level == LW'(DEPTH), "R5 full level", 64'(stk_level), DEPTH);
        step(0, '0, 1, 0, 32'h4000, 16'h0DD0, 0);
        check(stk_err == 1 && irq_pend == 1 && redir_vld == 0, "R8 push on full",
              64'({stk_err, irq_pend, redir_vld}), 64'(3'b110));
        check(stk_level == LW'(DEPTH), "R8 level unchanged", 64'(stk_level), DEPTH);

        // R6: LIFO pops
        for (int i = DEPTH - 1; i >= 0; i--) begin
            step(0, '0, 0, 0, '0, '0, 1);
            check(redir_pc == 32'h3000 + 32'(i * 4), "R6 lifo pc",
                  64'(redir_pc), 64'(32'h3000 + 32'(i * 4)));
        end

        // R8/R9: pop on empty after fresh reset
        do_reset();
        step(0, '0, 0, 0, '0, '0, 1);
        check(stk_err == 1 && redir_vld == 0, "R8 pop on empty",
              64'({stk_err, redir_vld}), 64'(2'b10));
        repeat (3) idle();
        check(stk_err == 1, "R9 sticky", 64'(stk_err), 1);

        // R2: load of zero arms nothing
        step(1, 16'd0, 0, 0, '0, '0, 0);
        repeat (4) idle();
        check(irq_pend == 0, "R2 zero load", 64'(irq_pend), 0);

        // random mix
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            bit wr, fc, sp, rti;
            wr  = ($urandom_range(0, 9) == 0);
            fc  = ($urandom_range(0, 1) == 0);
            sp  = ($urandom_range(0, 3) == 0);
            rti = ($urandom_range(0, 11) == 0);
            step(wr, 16'($urandom_range(0, 7)), fc, sp, $urandom(),
                 16'($urandom()), rti);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule